// File: doc/BRIEF.md
# Function-Coded 32-bit ALU

A purely combinational arithmetic logic unit for a 32-bit datapath. Two operands `a_i` and `b_i` and a 6-bit function code `fn_i` go in; a 32-bit result and three condition flags come out. Inside are five units:

- an adder/subtractor;
- a multiplier that keeps only the low half of the product;
- a bitwise boolean unit;
- a barrel shifter;
- a signed comparator.

The top two bits of the function code steer a 4-way multiplexer that picks which unit drives the result.

Every arithmetic path is built from gate-level cells: ripple-carry full adders, AND-gate partial products and mux stages. None of it uses built-in add, multiply or compare operators. The zero, overflow and negative flags always come from the adder/subtractor. The comparator reuses that subtraction, so a compare costs no extra adder.

The function code is laid out so that each unit decodes only a few low bits:

- bits [3:0] are the boolean truth table;
- bits [1:0] give the shift direction and fill;
- bits [2:1] give the compare type;
- bits [1:0] give multiply and subtract.

Top module: `fn_alu`

## Requirements
- R1: Code 0x00 (ADD) gives result = (A + B) mod 2^32.
- R2: Code 0x01 (SUB) gives result = (A - B) mod 2^32.
- R3: For every code, the adder subtracts when fn[0]=1 or fn[5:4]=11 and adds otherwise. N is bit 31 of its output, and Z is 1 exactly when that output is zero. V is 1 when A and the possibly inverted B share a sign and the output's sign differs from it.
- R4: When fn[5:4]=00 and fn[1]=1, the result is the low 32 bits of A*B whatever fn[0] is, so both 0x02 (MUL) and 0x03 select it. Signed and unsigned operands give the same result.
- R5: When fn[5:4]=01, result bit i = fn[{B[i],A[i]}], with B[i] as the upper index bit. This gives AND=0x18, OR=0x1E, XOR=0x16 and pass-A=0x1A.
- R6: Code 0x20 (SHL) shifts A left by B[4:0] with zero fill. B[31:5] has no effect.
- R7: Code 0x21 (SHR) shifts A right by B[4:0] with zero fill. Code 0x23 (SRA) fills with A[31].
- R8: When fn[5:4]=11, result bits [31:1] are zero. When fn[2:1]=00 in that group, bit 0 is also zero.
- R9: Code 0x33 (CMPEQ) gives result 1 when A equals B and 0 otherwise.
- R10: Code 0x35 (CMPLT) gives 1 when A < B as signed numbers. Code 0x37 (CMPLE) gives 1 when A <= B as signed numbers. Both stay correct when A - B overflows.
- R11: With all inputs zero, the result is 0 with Z=1, V=0 and N=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; bits [4:0] are the shift amount |
| fn_i | input | 6 | Function code |
| result_o | output | 32 | Selected unit's output |
| z_o | output | 1 | Adder/subtractor output is zero |
| v_o | output | 1 | Adder/subtractor signed overflow |
| n_o | output | 1 | Adder/subtractor output sign bit |

## Verification
The bench targets the following corner cases:

- **Overflow:** signed overflow in both directions, such as max-positive plus one and min-negative minus one. A V formula that ignores the operand inversion would flag the wrong one.
- **Compares against the minimum negative:** a comparator that used N alone instead of N xor V would invert the answer there.
- **Negative multiplicands:** -1 and -3 exercise the truncated multiplier. A multiplier that mishandled the partial-product alignment would corrupt the high result bits.
- **Shifts:** amounts of 0 and 31, with junk in B[31:5] and a set sign bit. These expose a wrong fill, a wrongly reversed left shift, or the high B bits leaking into the shift amount.
- **Function-code sweep:** random codes across all 64 values catch any unit that decodes a bit it should ignore.

// File: rtl/fn_alu_pkg.sv
package fn_alu_pkg;
  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_BOOL  = 2'b01,
    GRP_SHIFT = 2'b10,
    GRP_CMP   = 2'b11
  } alu_grp_e;

  localparam logic [5:0] OP_ADD   = 6'h00;
  localparam logic [5:0] OP_SUB   = 6'h01;
  localparam logic [5:0] OP_MUL   = 6'h02;
  localparam logic [5:0] OP_AND   = 6'h18;
  localparam logic [5:0] OP_OR    = 6'h1E;
  localparam logic [5:0] OP_XOR   = 6'h16;
  localparam logic [5:0] OP_PASSA = 6'h1A;
  localparam logic [5:0] OP_SHL   = 6'h20;
  localparam logic [5:0] OP_SHR   = 6'h21;
  localparam logic [5:0] OP_SRA   = 6'h23;
  localparam logic [5:0] OP_CMPEQ = 6'h33;
  localparam logic [5:0] OP_CMPLT = 6'h35;
  localparam logic [5:0] OP_CMPLE = 6'h37;
endpackage

// File: rtl/fn_alu_rca.sv
// Ripple-carry adder built from full-adder cells; carry out of the MSB is not needed.
module fn_alu_rca #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
    if (i < W - 1) begin : g_cy
      assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/fn_alu_addsub.sv
module fn_alu_addsub #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          z_o,
  output logic          v_o,
  output logic          n_o
);
  localparam int unsigned MSB = DW - 1;

  logic [DW-1:0] b_eff;

  assign b_eff = b_i ^ {DW{sub_i}};

  fn_alu_rca #(.W(DW)) u_rca (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (sub_i),
    .sum_o (sum_o)
  );

  assign z_o = ~|sum_o;
  assign n_o = sum_o[MSB];
  assign v_o = ~(a_i[MSB] ^ b_eff[MSB]) & (sum_o[MSB] ^ a_i[MSB]);

  always_comb begin
    if (sub_i && (a_i == b_i)) begin
      AST_SELF_SUB_ZERO: assert (z_o && !v_o); // R3
    end
    if (!sub_i && (b_i == '0)) begin
      AST_ADD_IDENTITY: assert (sum_o == a_i); // R1
    end
  end
endmodule

// File: rtl/fn_alu_mul.sv
// Array multiplier keeping the low DW bits; each row adds one shifted AND partial product.
module fn_alu_mul #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] prod_o
);
  logic [DW-1:0] pp  [DW];
  logic [DW-1:0] acc [DW];

  for (genvar j = 0; j < DW; j++) begin : g_row
    for (genvar i = 0; i < DW; i++) begin : g_col
      if (i >= j) begin : g_and
        assign pp[j][i] = a_i[i-j] & b_i[j];
      end else begin : g_zero
        assign pp[j][i] = 1'b0;
      end
    end

    if (j == 0) begin : g_first
      assign acc[0] = pp[0];
    end else begin : g_add
      fn_alu_rca #(.W(DW)) u_rca (
        .a_i   (acc[j-1]),
        .b_i   (pp[j]),
        .cin_i (1'b0),
        .sum_o (acc[j])
      );
    end
  end

  assign prod_o = acc[DW-1];

  always_comb begin
    if (b_i == '0) begin
      AST_MUL_BY_ZERO: assert (prod_o == '0); // R4
    end
    if (b_i == {{(DW-1){1'b0}}, 1'b1}) begin
      AST_MUL_BY_ONE: assert (prod_o == a_i); // R4
    end
  end
endmodule

// File: rtl/fn_alu_bool.sv
module fn_alu_bool #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [3:0]    tt_i,
  output logic [DW-1:0] out_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign out_o[i] = tt_i[{b_i[i], a_i[i]}];
  end

  always_comb begin
    if (tt_i == 4'b1010) begin
      AST_PASS_A: assert (out_o == a_i); // R5
    end
  end
endmodule

// File: rtl/fn_alu_shift.sv
// Log-stage right shifter; left shifts reuse it by reversing bit order on both sides.
module fn_alu_shift #(
  parameter int unsigned DW  = 32,
  parameter int unsigned SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  a_i,
  input  logic [SHW-1:0] amt_i,
  input  logic           right_i,
  input  logic           arith_i,
  output logic [DW-1:0]  out_o
);
  logic [DW-1:0] a_rev;
  logic [DW-1:0] src;
  logic [DW-1:0] res_rev;
  logic [DW-1:0] stg [SHW+1];
  logic          fill;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign a_rev[i]   = a_i[DW-1-i];
    assign res_rev[i] = stg[SHW][DW-1-i];
  end

  assign fill   = right_i & arith_i & a_i[DW-1];
  assign src    = right_i ? a_i : a_rev;
  assign stg[0] = src;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    for (genvar i = 0; i < DW; i++) begin : g_bit
      if (i + (2 ** s) < DW) begin : g_mv
        assign stg[s+1][i] = amt_i[s] ? stg[s][i + (2 ** s)] : stg[s][i];
      end else begin : g_fill
        assign stg[s+1][i] = amt_i[s] ? fill : stg[s][i];
      end
    end
  end

  assign out_o = right_i ? stg[SHW] : res_rev;

  always_comb begin
    if (amt_i == '0) begin
      AST_ZERO_SHIFT: assert (out_o == a_i); // R6
    end
  end
endmodule

// File: rtl/fn_alu_cmp.sv
module fn_alu_cmp #(
  parameter int unsigned DW = 32
) (
  input  logic          z_i,
  input  logic          v_i,
  input  logic          n_i,
  input  logic [1:0]    kind_i,
  output logic [DW-1:0] out_o
);
  logic lt;
  logic hit;

  assign lt = n_i ^ v_i;

  always_comb begin
    unique case (kind_i)
      2'b01:   hit = z_i;
      2'b10:   hit = lt;
      2'b11:   hit = z_i | lt;
      default: hit = 1'b0;
    endcase
  end

  assign out_o = {{(DW-1){1'b0}}, hit};
endmodule

// File: rtl/fn_alu.sv
module fn_alu
  import fn_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [5:0]    fn_i,
  output logic [DW-1:0] result_o,
  output logic          z_o,
  output logic          v_o,
  output logic          n_o
);
  localparam int unsigned SHW = $clog2(DW);

  alu_grp_e      grp;
  logic          sub;
  logic [DW-1:0] sum;
  logic [DW-1:0] prod;
  logic [DW-1:0] bool_out;
  logic [DW-1:0] shift_out;
  logic [DW-1:0] cmp_out;
  logic [DW-1:0] arith_out;

  assign grp = alu_grp_e'(fn_i[5:4]);
  // Comparisons always need A - B.
  assign sub = fn_i[0] | (grp == GRP_CMP);

  fn_alu_addsub #(.DW(DW)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub),
    .sum_o (sum),
    .z_o   (z_o),
    .v_o   (v_o),
    .n_o   (n_o)
  );

  fn_alu_mul #(.DW(DW)) u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  fn_alu_bool #(.DW(DW)) u_bool (
    .a_i   (a_i),
    .b_i   (b_i),
    .tt_i  (fn_i[3:0]),
    .out_o (bool_out)
  );

  fn_alu_shift #(.DW(DW), .SHW(SHW)) u_shift (
    .a_i     (a_i),
    .amt_i   (b_i[SHW-1:0]),
    .right_i (fn_i[0]),
    .arith_i (fn_i[1]),
    .out_o   (shift_out)
  );

  fn_alu_cmp #(.DW(DW)) u_cmp (
    .z_i    (z_o),
    .v_i    (v_o),
    .n_i    (n_o),
    .kind_i (fn_i[2:1]),
    .out_o  (cmp_out)
  );

  assign arith_out = fn_i[1] ? prod : sum;

  always_comb begin
    unique case (grp)
      GRP_ARITH: result_o = arith_out;
      GRP_BOOL:  result_o = bool_out;
      GRP_SHIFT: result_o = shift_out;
      default:   result_o = cmp_out;
    endcase
  end

  always_comb begin
    if (grp == GRP_CMP) begin
      AST_CMP_UPPER_ZERO: assert (result_o[DW-1:1] == '0); // R8
    end
    if (fn_i == OP_CMPEQ && a_i == b_i) begin
      AST_CMPEQ_TRUE: assert (result_o[0]); // R9
    end
  end
endmodule

// File: tb/fn_alu_test.sv
module fn_alu_test;
  import fn_alu_pkg::*;

  logic        clk;
  logic        rst_ni;
  logic [31:0] a, b, res;
  logic [5:0]  fn;
  logic        z, v, n;
  int          checks;
  int          fails;
  bit          done;

  fn_alu uut (
    .a_i      (a),
    .b_i      (b),
    .fn_i     (fn),
    .result_o (res),
    .z_o      (z),
    .v_o      (v),
    .n_o      (n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Returns {result, z, v, n}.
  function automatic logic [34:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [5:0] f);
    logic        s;
    logic [31:0] ye, sm, r;
    logic        zz, vv, nn;
    s  = f[0] | (f[5:4] == 2'b11);
    ye = s ? ~y : y;
    sm = x + ye + {31'd0, s};
    nn = sm[31];
    zz = (sm == 32'd0);
    vv = (x[31] == ye[31]) && (sm[31] != x[31]);
    case (f[5:4])
      2'b00: r = f[1] ? x * y : sm;
      2'b01: for (int i = 0; i < 32; i++) r[i] = f[{y[i], x[i]}];
      2'b10: begin
        if (!f[0])     r = x << y[4:0];
        else if (f[1]) r = $unsigned($signed(x) >>> y[4:0]);
        else           r = x >> y[4:0];
      end
      default: begin
        r = 32'd0;
        case (f[2:1])
          2'b01: r[0] = zz;
          2'b10: r[0] = nn ^ vv;
          2'b11: r[0] = zz | (nn ^ vv);
          default: r[0] = 1'b0;
        endcase
      end
    endcase
    return {r, zz, vv, nn};
  endfunction

  function automatic string tag_of(input logic [5:0] f);
    case (f[5:4])
      2'b00:   return f[1] ? "R4" : (f[0] ? "R2" : "R1");
      2'b01:   return "R5";
      2'b10:   return f[0] ? "R7" : "R6";
      default: return (f[2:1] == 2'b01) ? "R9" : ((f[2:1] == 2'b00) ? "R8" : "R10");
    endcase
  endfunction

  task automatic check(input logic [31:0] x, input logic [31:0] y, input logic [5:0] f,
                       input string req);
    logic [34:0] exp;
    @(negedge clk);
    a  = x;
    b  = y;
    fn = f;
    #2;
    exp = model(x, y, f);
    checks++;
    if (res !== exp[34:3]) begin
      fails++;
      $display("FAIL %s result fn=%h a=%h b=%h actual=%h expected=%h", req, f, x, y, res, exp[34:3]);
    end
    checks++;
    if ({z, v, n} !== exp[2:0]) begin
      fails++;
      $display("FAIL R3 flags (%s) fn=%h a=%h b=%h actual zvn=%b expected zvn=%b",
               req, f, x, y, {z, v, n}, exp[2:0]);
    end
  endtask

  initial begin
    logic [5:0] ops [13];
    ops = '{OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR, OP_PASSA,
            OP_SHL, OP_SHR, OP_SRA, OP_CMPEQ, OP_CMPLT, OP_CMPLE};
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    a = '0; b = '0; fn = '0;
    rst_ni = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    check(32'h0, 32'h0, OP_ADD, "R11");
    check(32'h7FFF_FFFF, 32'h1, OP_ADD, "R1");
    check(32'h7FFF_FFFF, 32'h7FFF_FFFF, OP_ADD, "R1");
    check(32'hFFFF_FFFF, 32'h1, OP_ADD, "R3");
    check(32'h0, 32'h7FFF_FFFF, OP_SUB, "R2");
    check(32'h8000_0000, 32'h1, OP_SUB, "R3");
    check(32'h5, 32'h9, OP_SUB, "R2");
    check(32'h6, 32'hFFFF_FFFD, OP_MUL, "R4");
    check(32'hFFFF_FFFF, 32'hFFFF_FFFF, OP_MUL, "R4");
    check(32'hDEAD_BEEF, 32'h0, OP_MUL, "R4");
    check(32'h1234_5678, 32'h9ABC_DEF1, 6'h03, "R4");
    check(32'hF0F0_1234, 32'hFF00_FF00, OP_AND, "R5");
    check(32'hF0F0_1234, 32'hFF00_FF00, OP_OR, "R5");
    check(32'hF0F0_1234, 32'hFF00_FF00, OP_XOR, "R5");
    check(32'hF0F0_1234, 32'hFF00_FF00, OP_PASSA, "R5");
    check(32'hF0F0_1234, 32'hFF00_FF00, 6'h11, "R5");
    check(32'h8000_0001, 32'hFFFF_FFE0, OP_SHL, "R6");
    check(32'h0000_0003, 32'hABCD_E01F, OP_SHL, "R6");
    check(32'h8000_0000, 32'h0000_001F, OP_SHR, "R7");
    check(32'h8000_0000, 32'h0000_001F, OP_SRA, "R7");
    check(32'h8765_4321, 32'hFFFF_FFE4, OP_SRA, "R7");
    check(32'h7654_3210, 32'h0000_0004, OP_SRA, "R7");
    check(32'hCAFE_0001, 32'hCAFE_0001, OP_CMPEQ, "R9");
    check(32'hCAFE_0001, 32'hCAFE_0002, OP_CMPEQ, "R9");
    check(32'h8000_0000, 32'h0000_0001, OP_CMPLT, "R10");
    check(32'h7FFF_FFFF, 32'h8000_0000, OP_CMPLT, "R10");
    check(32'hFFFF_FFFF, 32'hFFFF_FFFF, OP_CMPLT, "R10");
    check(32'hFFFF_FFFF, 32'hFFFF_FFFF, OP_CMPLE, "R10");
    check(32'h0000_0002, 32'hFFFF_FFFE, OP_CMPLE, "R10");
    check(32'h1234_5678, 32'h1234_5678, 6'h31, "R8");

    for (int k = 0; k < 800; k++) begin
      logic [5:0] f;
      f = ops[$urandom_range(12, 0)];
      check($urandom, $urandom, f, tag_of(f));
    end
    for (int k = 0; k < 400; k++) begin
      logic [5:0] f;
      f = 6'($urandom);
      check($urandom, $urandom, f, tag_of(f));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before the test completed");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule